// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block owns the 32-bit control/status word of a floating-point unit. Software reaches it through two move ports: a move-to-control port that loads a new value from an integer register, and a move-from-control port that returns a control register's contents for writeback to an integer register. The arithmetic datapath reports each completed operation as a valid strobe with five exception events, plus a comparison result and a condition-code selector when the operation is a compare.

For every operation the unit replaces the per-operation cause field with the new events and ORs the same events into the sticky flags. It then decides in the same cycle whether a floating-point trap must be raised, which is the case when a freshly written cause bit has its enable set. A trap withholds the destination writeback, or for a compare leaves the condition code untouched. A control write that leaves an enabled cause bit pending also raises the trap at once. The rounding mode, the flush bit and the eight condition codes drive the rest of the unit directly.

Bit layout, low to high: rounding mode 1:0 (0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf). Flags 6:2, enables 11:7 and cause 16:12 all use the same event order: inexact, underflow, overflow, divide-by-zero, invalid. Bit 17 is the unimplemented-operation cause. Condition code 0 is at bit 23, flush at bit 24, and condition codes 1 to 7 at bits 31:25.

Top module: `fpcsr_unit`

## Requirements
- R1: A read of control index 31 returns the whole status word, a read of any other index (index 0 included) returns zero, and a read whose destination integer register is 0 is discarded (rdWrEn low).
- R2: A control write to index 31 changes only bits 24, 11:7, 6:2 and 1:0 and leaves all other bits as they were; a write to any other index changes nothing; a write whose source integer register is 0 writes the value zero.
- R3: rndMode shows bits 1:0 with the encoding 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf, and flushEn shows bit 24.
- R4: Each operation strobe replaces all of bits 17:12 with its events: inexact bit 12, underflow 13, overflow 14, divide-by-zero 15, invalid 16, and bit 17 cleared.
- R5: Each event of an operation ORs into its sticky flag (inexact bit 2 up to invalid bit 6), and flags are cleared only by reset or by a control write.
- R6: When a new cause bit meets its enable (inexact enable bit 7 up to invalid bit 11), fpTrap is high in the strobe cycle, resWrEn stays low, and a compare leaves its condition code unchanged.
- R7: A control write whose resulting word has a cause bit set together with its enable raises fpTrap in the write cycle; otherwise fpTrap stays low.
- R8: A non-trapping compare writes its result into the condition code chosen by the 3-bit selector (code 0 at bit 23, code k at bit 24+k) and touches no other code; ccBits[k] shows code k.
- R9: Reset clears the whole word to zero.
- R10: A non-compare operation that does not trap asserts resWrEn in its strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Move-to-control strobe |
| ctlWrIdx | input | 5 | Control register index written |
| ctlSrcReg | input | 5 | Integer source register number |
| ctlSrcData | input | 32 | Integer source register value |
| ctlRdEn | input | 1 | Move-from-control strobe |
| ctlRdIdx | input | 5 | Control register index read |
| ctlRdDst | input | 5 | Integer destination register number |
| rdData | output | 32 | Value read from the control register |
| rdWrEn | output | 1 | Integer writeback enable for the read |
| opValid | input | 1 | Operation complete strobe |
| opEvents | input | 5 | Exception events of the operation |
| opIsCmp | input | 1 | Operation is a compare |
| opCcSel | input | 3 | Condition code selected by a compare |
| opCmpTrue | input | 1 | Compare result |
| resWrEn | output | 1 | Destination writeback allowed |
| fpTrap | output | 1 | Floating-point trap request |
| rndMode | output | 2 | Current rounding mode |
| flushEn | output | 1 | Flush-to-zero enable |
| ccBits | output | 8 | Condition codes 0 to 7 |

## Verification
The hardest case is a trap raised by a control write, because it needs a cause bit left pending by an earlier trapping operation and then a write that keeps the matching enable set. The bench builds it in order: it enables invalid, sends an invalid operation that traps, and then rewrites the word with the same enable and checks that fpTrap rises in the write cycle, while a second write with the enable cleared does not trap. Compares under a pending trap are checked by reading the word back to confirm the selected code did not change.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int CSR_W     = 32;
  localparam int EV_W      = 5;
  localparam int RM_LO     = 0;
  localparam int FLAG_LO   = 2;
  localparam int EN_LO     = 7;
  localparam int CAUSE_LO  = 12;
  localparam int CAUSE_W   = 6;
  localparam int CC0_POS   = 23;
  localparam int FLUSH_POS = 24;
  localparam int CCHI_LO   = 25;

  // Bits a control write may change.
  localparam logic [CSR_W-1:0] WR_MASK =
      (32'h1 << FLUSH_POS) | (32'h1F << EN_LO) | (32'h1F << FLAG_LO) | 32'h3;

  function automatic int ccPos(input int k);
    return (k == 0) ? CC0_POS : (CCHI_LO - 1 + k);
  endfunction

  typedef struct packed {
    logic             ctlAny;
    logic             ctlHit;
    logic [CSR_W-1:0] ctlVal;
    logic             opUpd;
    logic [EV_W-1:0]  ev;
    logic             ccWr;
    logic [2:0]       ccSel;
    logic             ccVal;
  } csrStrobe_t;
endpackage

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int CSR_IDX = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctlWrEn,
  input  logic [IDX_W-1:0] ctlWrIdx,
  input  logic [IDX_W-1:0] ctlSrcReg,
  input  logic [CSR_W-1:0] ctlSrcData,
  input  logic             ctlRdEn,
  input  logic [IDX_W-1:0] ctlRdIdx,
  input  logic [IDX_W-1:0] ctlRdDst,
  input  logic             opValid,
  input  logic [EV_W-1:0]  opEvents,
  input  logic             opIsCmp,
  input  logic [2:0]       opCcSel,
  input  logic             opCmpTrue,
  input  logic [CSR_W-1:0] csrQ,
  input  logic             trapNext,
  output csrStrobe_t       stb,
  output logic [CSR_W-1:0] rdData,
  output logic             rdWrEn,
  output logic             resWrEn
);
  logic [CSR_W-1:0] srcVal;

  always_comb begin
    srcVal     = (ctlSrcReg == '0) ? '0 : ctlSrcData;
    stb.ctlAny = ctlWrEn;
    stb.ctlHit = ctlWrEn && (ctlWrIdx == IDX_W'(CSR_IDX));
    stb.ctlVal = srcVal;
    // Control write wins over a colliding operation strobe.
    stb.opUpd  = opValid && !ctlWrEn;
    stb.ev     = opEvents;
    stb.ccWr   = stb.opUpd && opIsCmp && !trapNext;
    stb.ccSel  = opCcSel;
    stb.ccVal  = opCmpTrue;
    resWrEn    = stb.opUpd && !opIsCmp && !trapNext;
    rdData     = (ctlRdIdx == IDX_W'(CSR_IDX)) ? csrQ : '0;
    rdWrEn     = ctlRdEn && (ctlRdDst != '0);
  end

  a_r6_trap_blocks_result: assert property (@(posedge clk) disable iff (!rst_n)
    trapNext |-> (!resWrEn && !stb.ccWr));

  a_r1_other_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlRdIdx != IDX_W'(CSR_IDX)) |-> (rdData == '0));

  a_r2_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctlWrEn && opValid));
endmodule

// File: rtl/fpcsr_dp.sv
module fpcsr_dp
  import fpcsr_pkg::*;
#(
  parameter int NUM_CC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  csrStrobe_t       stb,
  output logic [CSR_W-1:0] csrQ,
  output logic             trapNext,
  output logic [1:0]       rndMode,
  output logic             flushEn,
  output logic [NUM_CC-1:0] ccBits
);
  logic [CSR_W-1:0] nxtBase, nxtFull;
  logic [NUM_CC-1:0] ccHit;

  always_comb begin
    nxtBase = csrQ;
    if (stb.ctlHit) begin
      nxtBase = (csrQ & ~WR_MASK) | (stb.ctlVal & WR_MASK);
    end else if (stb.opUpd) begin
      nxtBase[CAUSE_LO +: CAUSE_W] = {1'b0, stb.ev};
      nxtBase[FLAG_LO +: EV_W]     = csrQ[FLAG_LO +: EV_W] | stb.ev;
    end
  end

  always_comb begin
    trapNext = (stb.ctlAny || stb.opUpd) &&
               (|(nxtBase[CAUSE_LO +: EV_W] & nxtBase[EN_LO +: EV_W]));
  end

  for (genvar k = 0; k < NUM_CC; k++) begin : g_cc
    assign ccHit[k]  = stb.ccWr && (stb.ccSel == 3'(k));
    assign ccBits[k] = csrQ[ccPos(k)];
  end

  always_comb begin
    nxtFull = nxtBase;
    for (int k = 0; k < NUM_CC; k++) begin
      if (ccHit[k]) nxtFull[ccPos(k)] = stb.ccVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csrQ <= '0;
    else        csrQ <= nxtFull;
  end

  assign rndMode = csrQ[RM_LO +: 2];
  assign flushEn = csrQ[FLUSH_POS];

  a_r4_cause_replaced: assert property (@(posedge clk) disable iff (!rst_n)
    stb.opUpd |=> (csrQ[CAUSE_LO +: CAUSE_W] == {1'b0, $past(stb.ev)}));

  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.ctlHit |=> ((csrQ[FLAG_LO +: EV_W] & $past(csrQ[FLAG_LO +: EV_W]))
                      == $past(csrQ[FLAG_LO +: EV_W])));

  a_r2_protected_bits: assert property (@(posedge clk) disable iff (!rst_n)
    stb.ctlAny |=> ((csrQ & ~WR_MASK) == ($past(csrQ) & ~WR_MASK)));

  a_r8_one_cc_written: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ccHit));
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int CSR_IDX = 31,
  parameter int NUM_CC  = 8,
  localparam int SEL_W  = $clog2(NUM_CC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlWrEn,
  input  logic [IDX_W-1:0]  ctlWrIdx,
  input  logic [IDX_W-1:0]  ctlSrcReg,
  input  logic [31:0]       ctlSrcData,
  input  logic              ctlRdEn,
  input  logic [IDX_W-1:0]  ctlRdIdx,
  input  logic [IDX_W-1:0]  ctlRdDst,
  output logic [31:0]       rdData,
  output logic              rdWrEn,
  input  logic              opValid,
  input  logic [4:0]        opEvents,
  input  logic              opIsCmp,
  input  logic [SEL_W-1:0]  opCcSel,
  input  logic              opCmpTrue,
  output logic              resWrEn,
  output logic              fpTrap,
  output logic [1:0]        rndMode,
  output logic              flushEn,
  output logic [NUM_CC-1:0] ccBits
);
  csrStrobe_t       stb;
  logic [CSR_W-1:0] csrQ;
  logic             trapNext;

  fpcsr_ctrl #(.IDX_W(IDX_W), .CSR_IDX(CSR_IDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctlWrEn(ctlWrEn), .ctlWrIdx(ctlWrIdx), .ctlSrcReg(ctlSrcReg),
    .ctlSrcData(ctlSrcData), .ctlRdEn(ctlRdEn), .ctlRdIdx(ctlRdIdx),
    .ctlRdDst(ctlRdDst), .opValid(opValid), .opEvents(opEvents),
    .opIsCmp(opIsCmp), .opCcSel(opCcSel), .opCmpTrue(opCmpTrue),
    .csrQ(csrQ), .trapNext(trapNext), .stb(stb), .rdData(rdData),
    .rdWrEn(rdWrEn), .resWrEn(resWrEn)
  );

  fpcsr_dp #(.NUM_CC(NUM_CC)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .csrQ(csrQ), .trapNext(trapNext),
    .rndMode(rndMode), .flushEn(flushEn), .ccBits(ccBits)
  );

  assign fpTrap = trapNext;

  a_r7_trap_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    fpTrap |-> (ctlWrEn || opValid));
endmodule

// File: tb/fpcsr_unit_tb.sv
module fpcsr_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctlWrEn = 0, ctlRdEn = 0, opValid = 0, opIsCmp = 0, opCmpTrue = 0;
  logic [4:0] ctlWrIdx = 0, ctlSrcReg = 0, ctlRdIdx = 0, ctlRdDst = 0, opEvents = 0;
  logic [31:0] ctlSrcData = 0;
  logic [2:0] opCcSel = 0;
  logic [31:0] rdData;
  logic rdWrEn, resWrEn, fpTrap, flushEn;
  logic [1:0] rndMode;
  logic [7:0] ccBits;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpcsr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ctlWrEn(ctlWrEn), .ctlWrIdx(ctlWrIdx),
    .ctlSrcReg(ctlSrcReg), .ctlSrcData(ctlSrcData), .ctlRdEn(ctlRdEn),
    .ctlRdIdx(ctlRdIdx), .ctlRdDst(ctlRdDst), .rdData(rdData), .rdWrEn(rdWrEn),
    .opValid(opValid), .opEvents(opEvents), .opIsCmp(opIsCmp), .opCcSel(opCcSel),
    .opCmpTrue(opCmpTrue), .resWrEn(resWrEn), .fpTrap(fpTrap), .rndMode(rndMode),
    .flushEn(flushEn), .ccBits(ccBits)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readWord(input string req, input logic [31:0] exp);
    @(negedge clk);
    ctlRdEn = 1; ctlRdIdx = 31; ctlRdDst = 4;
    #5 chk(req, rdData, exp);
    ctlRdEn = 0; ctlRdIdx = 0; ctlRdDst = 0;
  endtask

  task automatic ctlWrite(input string req, input logic [4:0] idx, input logic [4:0] src,
                          input logic [31:0] data, input logic expTrap);
    @(negedge clk);
    ctlWrEn = 1; ctlWrIdx = idx; ctlSrcReg = src; ctlSrcData = data;
    #5 chk(req, 32'(fpTrap), 32'(expTrap));
    @(posedge clk); #1;
    ctlWrEn = 0; ctlWrIdx = 0; ctlSrcReg = 0; ctlSrcData = 0;
  endtask

  task automatic doOp(input string req, input logic [4:0] ev, input logic cmp,
                      input logic [2:0] sel, input logic val,
                      input logic expTrap, input logic expRes);
    @(negedge clk);
    opValid = 1; opEvents = ev; opIsCmp = cmp; opCcSel = sel; opCmpTrue = val;
    #5;
    chk(req, 32'(fpTrap), 32'(expTrap));
    chk(req, 32'(resWrEn), 32'(expRes));
    @(posedge clk); #1;
    opValid = 0; opEvents = 0; opIsCmp = 0; opCcSel = 0; opCmpTrue = 0;
  endtask

  task automatic testReset();
    readWord("R9 reset word", 32'h0);
    chk("R9 reset rnd", 32'(rndMode), 0);
    chk("R9 reset cc", 32'(ccBits), 0);
    chk("R9 reset trap", 32'(fpTrap), 0);
  endtask

  task automatic testCtlWrite();
    ctlWrite("R2 write all", 31, 5, 32'hFFFF_FFFF, 1'b0);
    readWord("R2 masked write", 32'h0100_0FFF);
    chk("R3 rnd toward -inf", 32'(rndMode), 3);
    chk("R3 flush", 32'(flushEn), 1);
    ctlWrite("R2 src reg zero", 31, 0, 32'hFFFF_FFFF, 1'b0);
    readWord("R2 zero source", 32'h0);
    ctlWrite("R3 rnd +inf", 31, 6, 32'h0000_0002, 1'b0);
    chk("R3 rnd toward +inf", 32'(rndMode), 2);
    ctlWrite("R2 other index", 5, 6, 32'h0100_0001, 1'b0);
    readWord("R2 other index ignored", 32'h0000_0002);
    ctlWrite("R2 clear", 31, 6, 32'h0, 1'b0);
  endtask

  task automatic testRead();
    @(negedge clk);
    ctlRdEn = 1; ctlRdIdx = 0; ctlRdDst = 3;
    #5 chk("R1 index 0 zero", rdData, 0);
    chk("R1 writeback enabled", 32'(rdWrEn), 1);
    ctlRdIdx = 7;
    #1 chk("R1 index 7 zero", rdData, 0);
    ctlRdIdx = 31; ctlRdDst = 0;
    #1 chk("R1 dest reg 0 discarded", 32'(rdWrEn), 0);
    ctlRdEn = 0; ctlRdIdx = 0;
  endtask

  task automatic testOps();
    doOp("R10 clean op", 5'b00101, 0, 0, 0, 1'b0, 1'b1);
    readWord("R4 R5 first op", 32'h0000_5014);
    doOp("R10 second op", 5'b01000, 0, 0, 0, 1'b0, 1'b1);
    readWord("R4 cause replaced R5 flags kept", 32'h0000_8034);
  endtask

  task automatic testTrap();
    ctlWrite("R7 no pending trap", 31, 6, 32'h0000_0800, 1'b0);
    readWord("R2 enable invalid", 32'h0000_8800);
    doOp("R6 trapping op", 5'b10000, 0, 0, 0, 1'b1, 1'b0);
    readWord("R6 word after trap", 32'h0001_0840);
    doOp("R8 compare cc3", 5'b00000, 1, 3, 1, 1'b0, 1'b0);
    readWord("R8 cc3 set", 32'h0800_0840);
    doOp("R6 trapping compare", 5'b10000, 1, 0, 1, 1'b1, 1'b0);
    readWord("R6 cc0 untouched", 32'h0801_0840);
    ctlWrite("R7 write keeps enabled cause", 31, 6, 32'h0000_0800, 1'b1);
    readWord("R7 word", 32'h0801_0800);
    ctlWrite("R7 write disables", 31, 6, 32'h0, 1'b0);
  endtask

  task automatic testCc();
    doOp("R8 cc0", 5'b0, 1, 0, 1, 1'b0, 1'b0);
    readWord("R8 cc0 bit23", 32'h0880_0000);
    chk("R8 ccBits a", 32'(ccBits), 32'h09);
    doOp("R8 cc7", 5'b0, 1, 7, 1, 1'b0, 1'b0);
    chk("R8 ccBits b", 32'(ccBits), 32'h89);
    doOp("R8 cc3 clear", 5'b0, 1, 3, 0, 1'b0, 1'b0);
    readWord("R8 cc7 bit31", 32'h8080_0000);
    chk("R8 ccBits c", 32'(ccBits), 32'h81);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    testReset();
    testCtlWrite();
    testRead();
    testOps();
    testTrap();
    testCc();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule